// File: doc/BRIEF.md
# Shared Cycle Counter with Per-Core Timer Compare

This block holds one free-running 64-bit cycle counter that several cores share, and a 64-bit compare value for each core. When the counter equals a core's compare value, that core's timer-pending flag is set and its timer interrupt line goes high. The flag stays set until software rewrites the low half of that core's compare value.

All state is reached over a single 32-bit register port. Each access carries the index of the requesting core. The requester sees its own registers in a local window. A second window shows the compare and pending registers of whichever core the requester's own selector register names, so one core can program another core's timer. The counter is read as two 32-bit halves. No half is latched, so software reads high, low, high and retries if the two high values differ. Reads are combinational in the cycle of the access. A write takes effect at the next rising clock edge.

Top module: `gtimer_bank`

## Requirements
- R1: The counter resets to 0. It adds one on every clock edge where `cnt_en` is high and holds otherwise, wrapping modulo 2^64.
- R2: Word address 1 reads counter bits 31:0 and address 2 reads bits 63:32, both showing the live counter value of that cycle. Writes to these addresses are ignored.
- R3: Address 0 reads the number of cores minus one in bits 7:0, with all other bits 0. Writes to it are ignored.
- R4: Addresses 4 (low half) and 5 (high half) write and read back the requesting core's own compare value. Every compare value resets to all ones.
- R5: When the counter equals a core's full 64-bit compare value at a clock edge, that core's pending flag is 1 from that edge onward. `tmr_irq[i]` always equals core i's pending flag.
- R6: A pending flag stays set until a write to the low half of that core's compare. A write to the high half alone leaves it set. A low-half write clears it at its edge, even when a match occurs at the same edge.
- R7: Address 6 reads the requester's pending flag in bit 0, with all other bits 0. Writes to it are ignored.
- R8: Address 7 is an 8-bit core selector held separately for each requesting core. It resets to 0 and reads back in bits 7:0.
- R9: Addresses 8 (compare low), 9 (compare high) and 10 (pending) access the core named by the requester's selector. These accesses behave exactly like that core's own addresses 4, 5 and 6.
- R10: When the requester's selector is not below the core count, addresses 8 to 10 read 0 and writes to them change nothing.
- R11: Unmapped addresses (3 and 11 to 15) read 0, and writes to them change nothing. `bus_rdata` is 0 whenever `bus_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| bus_vld | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_core | input | IDW | Index of the requesting core |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tmr_irq | output | NCORES | Timer interrupt per core |

## Verification
The bench builds the block with three cores and the default 8-bit selector. With three cores, selector values of 3 and above are legal to write but point at no core, so the out-of-range path of the other-core window can be exercised. A core count that is not a power of two also tests the index decode at a non-binary boundary. Three cores also allow chains such as core 1 programming core 2 while core 0 points its own selector elsewhere. A behavioural model tracks the counter, the compare values, the flags and the selectors, and it predicts every read and every interrupt line on every clock. Some compare targets are placed so that a low-half write lands exactly on the matching edge. Counter wrap at 2^64 is covered by an assertion rather than reached by the bench.

// File: rtl/gtimer_bank.sv
module gtimer_bank #(
  parameter int NCORES = 4,
  parameter int SELW   = 8,
  parameter int IDW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [IDW-1:0]    bus_core,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCORES-1:0] tmr_irq
);
  localparam logic [3:0] A_CFG = 4'd0, A_CLO = 4'd1, A_CHI = 4'd2;
  localparam logic [3:0] A_LLO = 4'd4, A_LHI = 4'd5, A_LPD = 4'd6, A_SEL = 4'd7;
  localparam logic [3:0] A_OLO = 4'd8, A_OHI = 4'd9, A_OPD = 4'd10;

  logic [63:0]     cnt;
  logic [63:0]     cmp [NCORES];
  logic [NCORES-1:0] pend;
  logic [SELW-1:0] sel [NCORES];
  logic [NCORES-1:0] wlo, whi;

  wire             req_ok   = bus_vld && (32'(bus_core) < NCORES);
  wire [SELW-1:0]  rsel     = req_ok ? sel[bus_core] : '0;
  wire             other_ok = 32'(rsel) < NCORES;
  wire [IDW-1:0]   otgt     = rsel[IDW-1:0];
  wire             do_wr    = req_ok && bus_wr;

  assign tmr_irq = pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt + 64'd1;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    wire mine = bus_core == IDW'(i);
    wire oth  = other_ok && otgt == IDW'(i);
    assign wlo[i] = do_wr && ((bus_addr == A_LLO && mine) || (bus_addr == A_OLO && oth));
    assign whi[i] = do_wr && ((bus_addr == A_LHI && mine) || (bus_addr == A_OHI && oth));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cmp[i]  <= '1;
        pend[i] <= 1'b0;
        sel[i]  <= '0;
      end else begin
        if (wlo[i]) cmp[i][31:0]  <= bus_wdata;
        if (whi[i]) cmp[i][63:32] <= bus_wdata;
        if (wlo[i])               pend[i] <= 1'b0;
        else if (cnt == cmp[i])   pend[i] <= 1'b1;
        if (do_wr && bus_addr == A_SEL && mine) sel[i] <= bus_wdata[SELW-1:0];
      end

    // R5
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == cmp[i] && !wlo[i]) |=> tmr_irq[i]);
    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_irq[i] && !wlo[i]) |=> tmr_irq[i]);
    // R6
    lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wlo[i] |=> !tmr_irq[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (req_ok)
      case (bus_addr)
        A_CFG: bus_rdata[7:0] = 8'(NCORES - 1);
        A_CLO: bus_rdata = cnt[31:0];
        A_CHI: bus_rdata = cnt[63:32];
        A_LLO: bus_rdata = cmp[bus_core][31:0];
        A_LHI: bus_rdata = cmp[bus_core][63:32];
        A_LPD: bus_rdata[0] = pend[bus_core];
        A_SEL: bus_rdata[SELW-1:0] = rsel;
        A_OLO: if (other_ok) bus_rdata = cmp[otgt][31:0];
        A_OHI: if (other_ok) bus_rdata = cmp[otgt][63:32];
        A_OPD: if (other_ok) bus_rdata[0] = pend[otgt];
        default: bus_rdata = '0;
      endcase
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt == $past(cnt) + 64'd1);
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));
  // R10
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && !other_ok && (bus_addr == A_OLO || bus_addr == A_OHI || bus_addr == A_OPD))
      |-> bus_rdata == 32'd0);
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |-> bus_rdata == 32'd0);
endmodule

// File: tb/sim_gtimer_bank.sv
module sim_gtimer_bank;
  localparam int NC = 3;
  localparam int IDW = 2;

  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0;
  logic bus_vld = 1'b0, bus_wr = 1'b0;
  logic [IDW-1:0] bus_core = '0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] tmr_irq;

  always #2 clk = ~clk;

  gtimer_bank #(.NCORES(NC), .SELW(8), .IDW(IDW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_irq(tmr_irq));

  int vectors = 0, errors = 0, cyc = 0;
  bit done = 0;
  longint unsigned mcnt;
  logic [63:0] mcmp [NC];
  bit mpend [NC];
  int msel [NC];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected under 100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic logic [31:0] exp_read(bit v, int core, int addr);
    int s;
    if (!v) return 0;
    s = msel[core];
    case (addr)
      0: return 32'(NC - 1);
      1: return mcnt[31:0];
      2: return mcnt[63:32];
      4: return mcmp[core][31:0];
      5: return mcmp[core][63:32];
      6: return {31'b0, mpend[core]};
      7: return 32'(s);
      8: return (s < NC) ? mcmp[s][31:0] : 0;
      9: return (s < NC) ? mcmp[s][63:32] : 0;
      10: return (s < NC) ? {31'b0, mpend[s]} : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit wr, int core, int addr, logic [31:0] wd, string tag);
    logic [31:0] er;
    logic [NC-1:0] ei;
    bit nm [NC];
    int s;
    bus_vld = v; bus_wr = wr; bus_core = IDW'(core); bus_addr = 4'(addr); bus_wdata = wd;
    #1;
    er = exp_read(v, core, addr);
    for (int i = 0; i < NC; i++) ei[i] = mpend[i];
    check(tag, bus_rdata, er);
    check("R5 irq", 32'(tmr_irq), 32'(ei));
    @(posedge clk);
    for (int i = 0; i < NC; i++) nm[i] = mpend[i] | (mcnt == mcmp[i]);
    if (v && wr) begin
      s = msel[core];
      case (addr)
        4: begin mcmp[core][31:0] = wd; nm[core] = 0; end
        5: mcmp[core][63:32] = wd;
        7: msel[core] = int'(wd[7:0]);
        8: if (s < NC) begin mcmp[s][31:0] = wd; nm[s] = 0; end
        9: if (s < NC) mcmp[s][63:32] = wd;
        default: ;
      endcase
    end
    for (int i = 0; i < NC; i++) mpend[i] = nm[i];
    if (cnt_en) mcnt = mcnt + 1;
    @(negedge clk);
  endtask

  task automatic idle(int n, int core, int addr, string tag);
    for (int k = 0; k < n; k++) step(1, 0, core, addr, 0, tag);
  endtask

  initial begin
    mcnt = 0;
    for (int i = 0; i < NC; i++) begin mcmp[i] = '1; mpend[i] = 0; msel[i] = 0; end
    repeat (3) @(negedge clk);
    bus_vld = 1; bus_addr = 4'd1; #1;
    check("R1 reset count", bus_rdata, 0);
    check("R5 reset irq", 32'(tmr_irq), 0);
    bus_vld = 0;
    rst_n = 1;
    @(negedge clk);
    cnt_en = 1;
    // R3 config, R4 reset compare, R11 unmapped / idle bus
    step(1, 0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 32'hffff, "R3");
    step(1, 0, 0, 0, 0, "R3");
    step(1, 0, 2, 4, 0, "R4");
    step(1, 0, 2, 5, 0, "R4");
    step(0, 0, 0, 1, 0, "R11");
    step(1, 0, 0, 3, 0, "R11");
    step(1, 1, 1, 15, 32'h1234, "R11");
    step(1, 0, 1, 15, 0, "R11");
    step(1, 1, 0, 1, 32'hdead, "R2");
    // R2 live counter, high/low/high
    step(1, 0, 0, 2, 0, "R2");
    step(1, 0, 0, 1, 0, "R2");
    step(1, 0, 0, 2, 0, "R2");
    // R1 pause
    cnt_en = 0;
    idle(4, 1, 1, "R1");
    cnt_en = 1;
    idle(2, 1, 1, "R1");
    // R4/R5 core0 own compare
    step(1, 1, 0, 5, 32'(mcnt >> 32), "R4");
    step(1, 1, 0, 4, 32'(mcnt + 10), "R4");
    step(1, 0, 0, 4, 0, "R4");
    idle(12, 0, 6, "R7");
    // R6 high write alone keeps pending
    step(1, 1, 0, 5, 32'h7, "R6");
    idle(3, 0, 6, "R6");
    step(1, 1, 0, 4, 32'h0, "R6");
    idle(2, 0, 6, "R6");
    // R6 clear coinciding with a match
    step(1, 1, 0, 5, 32'(mcnt >> 32), "R6");
    step(1, 1, 0, 4, 32'(mcnt + 6), "R6");
    while (mcnt != mcmp[0]) step(1, 0, 0, 6, 0, "R6");
    step(1, 1, 0, 4, 32'(mcnt + 1000), "R6");
    idle(3, 0, 6, "R6");
    // R8/R9 core1 programs core2
    step(1, 1, 1, 7, 32'h2, "R8");
    step(1, 0, 1, 7, 0, "R8");
    step(1, 1, 0, 7, 32'h1, "R8");
    step(1, 0, 0, 7, 0, "R8");
    step(1, 1, 1, 9, 32'(mcnt >> 32), "R9");
    step(1, 1, 1, 8, 32'(mcnt + 8), "R9");
    step(1, 0, 2, 4, 0, "R9");
    idle(10, 1, 10, "R9");
    step(1, 0, 2, 6, 0, "R9");
    step(1, 1, 0, 9, 32'h55, "R9");
    step(1, 0, 1, 5, 0, "R9");
    step(1, 0, 0, 9, 0, "R9");
    // R10 out-of-range selector
    step(1, 1, 1, 7, 32'h3, "R10");
    step(1, 0, 1, 8, 0, "R10");
    step(1, 0, 1, 10, 0, "R10");
    step(1, 1, 1, 8, 32'h0, "R10");
    step(1, 1, 1, 9, 32'h0, "R10");
    step(1, 0, 2, 6, 0, "R10");
    step(1, 0, 0, 4, 0, "R10");
    step(1, 0, 1, 4, 0, "R10");
    step(1, 1, 2, 7, 32'hff, "R10");
    step(1, 0, 2, 9, 0, "R10");
    idle(4, 2, 2, "R2");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule